// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps one status byte for each finished transmission, in a first-in, first-out store of parameterised depth. A completion pulse arrives with four qualifier flags: interrupt-on-success requested, jabber, underrun and maximum collisions. The byte built from them is queued. The host always sees the oldest queued byte at the status output. Writing the status register (a one-cycle pop strobe) discards that byte and exposes the next one.

When the store is already full, a new completion is dropped. The newest stored byte is then marked with an overflow flag, so software learns that records went missing. A completion that asked for an interrupt, or that carries any error, raises a one-cycle transmit-complete event. A jabber or underrun error also raises a transmitter hold request. The hold stays up until a TX reset command, and that command also empties the store.

Top module: `txstat_stack`

## Requirements
- R1: After reset, status_o is 0x00, done_evt_o is 0 and tx_hold_o is 0.
- R2: A stored status byte has bit 7 = 1 (complete), bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow (0 when pushed), and bits 1:0 always 0.
- R3: Entries leave in arrival order. status_o shows the oldest entry in the cycle after its push edge. A pop strobe removes the head at the next edge. The default depth is 4.
- R4: With the store empty, status_o reads 0x00, and a pop strobe has no effect on later contents.
- R5: A completion that arrives while the store is full, with no pop in the same cycle, is dropped. Bit 2 of the newest stored entry is set, and older entries are unchanged.
- R6: done_evt_o pulses for one cycle, in the cycle after a completion that has the interrupt request or any error flag. A completion with no flags is still stored but raises no event.
- R7: A completion with jabber or underrun sets tx_hold_o from the next cycle on. The hold stays set until a TX reset. A completion with only maximum collisions does not set it.
- R8: A TX reset strobe empties the store and clears tx_hold_o at the next edge. It overrides a completion or a pop in the same cycle; such a completion is neither stored nor signalled.
- R9: A completion and a pop in the same cycle on a full store are both carried out, and no overflow is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | One-cycle transmission completion pulse |
| irq_req_i | input | 1 | Interrupt on success requested (qualifies done_i) |
| jabber_i | input | 1 | Jabber error (qualifies done_i) |
| underrun_i | input | 1 | Underrun error (qualifies done_i) |
| max_coll_i | input | 1 | Maximum collisions reached (qualifies done_i) |
| pop_i | input | 1 | Status register write strobe; pops the head |
| tx_reset_i | input | 1 | TX reset command strobe |
| status_o | output | 8 | Head status byte, 0x00 when empty |
| done_evt_o | output | 1 | Transmit-complete event pulse |
| tx_hold_o | output | 1 | Request that the transmitter stay disabled |

## Verification
The assertions assume that done_i, pop_i and tx_reset_i are single-cycle strobes sampled at the rising edge. They also assume that the flag inputs matter only while done_i is high. The directed stimulus drives every input on the falling edge and returns the strobes to zero after one cycle. Each scenario starts from an empty store with the hold cleared, reached through reset or through a TX reset. Pops on an empty store are issued on purpose, to exercise the no-effect case.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

    localparam int unsigned STAT_W    = 8;
    localparam int unsigned B_DONE    = 7;
    localparam int unsigned B_IRQ     = 6;
    localparam int unsigned B_JABBER  = 5;
    localparam int unsigned B_UNDERUN = 4;
    localparam int unsigned B_MAXCOLL = 3;
    localparam int unsigned B_OVFL    = 2;

    typedef struct packed {
        logic irq;
        logic jabber;
        logic underrun;
        logic max_coll;
    } tx_flags_t;

    function automatic logic [STAT_W-1:0] pack_status(input tx_flags_t f);
        logic [STAT_W-1:0] b;
        b            = '0;
        b[B_DONE]    = 1'b1;
        b[B_IRQ]     = f.irq;
        b[B_JABBER]  = f.jabber;
        b[B_UNDERUN] = f.underrun;
        b[B_MAXCOLL] = f.max_coll;
        return b;
    endfunction

endpackage

// File: rtl/txstat_fifo.sv
module txstat_fifo
    import txstat_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              mark_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic [STAT_W-1:0] rdata_o,
    output logic              empty_o,
    output logic              full_o
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] count;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [STAT_W-1:0] mem_d [DEPTH];
    logic [STAT_W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    logic          do_pop;
    logic [PW-1:0] newest;

    always_comb begin
        s_d    = s_q;
        mem_d  = mem_q;
        do_pop = pop_i && (s_q.count != '0);
        newest = (s_q.tail == '0) ? LAST : s_q.tail - 1'b1;
        if (clr_i) begin
            s_d.head  = '0;
            s_d.tail  = '0;
            s_d.count = '0;
        end else begin
            if (mark_i && (s_q.count != '0)) begin
                mem_d[newest][B_OVFL] = 1'b1;
            end
            if (push_i) begin
                mem_d[s_q.tail] = wdata_i;
                s_d.tail        = wrap_inc(s_q.tail);
            end
            if (do_pop) begin
                s_d.head = wrap_inc(s_q.head);
            end
            s_d.count = s_q.count + CW'(push_i) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            s_q   <= s_d;
            mem_q <= mem_d;
        end
    end

    assign empty_o = (s_q.count == '0);
    assign full_o  = (s_q.count == CW'(DEPTH));
    assign rdata_o = empty_o ? '0 : mem_q[s_q.head];

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CW'(DEPTH));

    a_r4_empty_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i && !clr_i) |=> empty_o);

    a_r5_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && mark_i && !pop_i && !clr_i) |=> full_o);

    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (empty_o && rdata_o == '0));

endmodule

// File: rtl/txstat_lock.sv
module txstat_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic done_i,
    input  logic fatal_i,
    input  logic notify_i,
    output logic hold_o,
    output logic evt_o
);

    typedef struct packed {
        logic hold;
        logic evt;
    } lock_t;

    lock_t l_d, l_q;

    always_comb begin
        l_d     = l_q;
        l_d.evt = done_i && notify_i && !clr_i;
        if (clr_i) begin
            l_d.hold = 1'b0;
        end else if (done_i && fatal_i) begin
            l_d.hold = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign hold_o = l_q.hold;
    assign evt_o  = l_q.evt;

    a_r7_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !clr_i) |=> hold_o);

    a_r8_reset_releases: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!hold_o && !evt_o));

    a_r6_evt_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(done_i));

    a_r6_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && !done_i) |=> !evt_o);

endmodule

// File: rtl/txstat_stack.sv
module txstat_stack
    import txstat_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              irq_req_i,
    input  logic              jabber_i,
    input  logic              underrun_i,
    input  logic              max_coll_i,
    input  logic              pop_i,
    input  logic              tx_reset_i,
    output logic [STAT_W-1:0] status_o,
    output logic              done_evt_o,
    output logic              tx_hold_o
);

    tx_flags_t         flags;
    logic [STAT_W-1:0] new_byte;
    logic              full, empty, push, mark, fatal, notify;

    always_comb begin
        flags.irq      = irq_req_i;
        flags.jabber   = jabber_i;
        flags.underrun = underrun_i;
        flags.max_coll = max_coll_i;
        new_byte       = pack_status(flags);
        fatal          = jabber_i || underrun_i;
        notify         = irq_req_i || jabber_i || underrun_i || max_coll_i;
        push           = done_i && !tx_reset_i && (!full || pop_i);
        mark           = done_i && !tx_reset_i && full && !pop_i;
    end

    txstat_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tx_reset_i),
        .push_i  (push),
        .pop_i   (pop_i),
        .mark_i  (mark),
        .wdata_i (new_byte),
        .rdata_o (status_o),
        .empty_o (empty),
        .full_o  (full)
    );

    txstat_lock i_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tx_reset_i),
        .done_i   (done_i),
        .fatal_i  (fatal),
        .notify_i (notify),
        .hold_o   (tx_hold_o),
        .evt_o    (done_evt_o)
    );

    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[1:0] == 2'b00);

    a_r2_head_complete: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |-> status_o[B_DONE]);

    a_r9_pop_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && done_i && pop_i && !tx_reset_i) |=> !empty);

endmodule

// File: tb/test_txstat_stack.sv
module test_txstat_stack;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       done_i = 1'b0, irq_req_i = 1'b0, jabber_i = 1'b0;
    logic       underrun_i = 1'b0, max_coll_i = 1'b0;
    logic       pop_i = 1'b0, tx_reset_i = 1'b0;
    logic [7:0] status_o;
    logic       done_evt_o, tx_hold_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    txstat_stack #(.DEPTH(4)) i_txstat_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done_i),
        .irq_req_i  (irq_req_i),
        .jabber_i   (jabber_i),
        .underrun_i (underrun_i),
        .max_coll_i (max_coll_i),
        .pop_i      (pop_i),
        .tx_reset_i (tx_reset_i),
        .status_o   (status_o),
        .done_evt_o (done_evt_o),
        .tx_hold_o  (tx_hold_o)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // One clock: drive at the falling edge, return to idle at the next falling edge.
    // flags = {irq, jabber, underrun, max_coll}
    task automatic step(input logic d, input logic [3:0] fl, input logic p, input logic tr);
        @(negedge clk);
        done_i     = d;
        irq_req_i  = fl[3];
        jabber_i   = fl[2];
        underrun_i = fl[1];
        max_coll_i = fl[0];
        pop_i      = p;
        tx_reset_i = tr;
        @(posedge clk);
        @(negedge clk);
        done_i = 0; irq_req_i = 0; jabber_i = 0; underrun_i = 0; max_coll_i = 0;
        pop_i = 0; tx_reset_i = 0;
    endtask

    task automatic push(input logic [3:0] fl);
        step(1'b1, fl, 1'b0, 1'b0);
    endtask

    task automatic pop_one();
        step(1'b0, 4'b0000, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 status", status_o, 8'h00);
        check("R1 event", {7'd0, done_evt_o}, 8'h00);
        check("R1 hold", {7'd0, tx_hold_o}, 8'h00);
    endtask

    task automatic t_encode();
        push(4'b1000);
        check("R2 irq byte", status_o, 8'hC0);
        check("R6 irq event", {7'd0, done_evt_o}, 8'h01);
        pop_one();
        check("R4 empty after pop", status_o, 8'h00);
        push(4'b0001);
        check("R2 maxcoll byte", status_o, 8'h88);
        check("R6 error event", {7'd0, done_evt_o}, 8'h01);
        check("R7 maxcoll no hold", {7'd0, tx_hold_o}, 8'h00);
        pop_one();
        push(4'b0000);
        check("R2 clean byte", status_o, 8'h80);
        check("R6 clean no event", {7'd0, done_evt_o}, 8'h00);
        pop_one();
    endtask

    task automatic t_order();
        push(4'b1000);
        push(4'b0001);
        check("R6 event one cycle", {7'd0, done_evt_o}, 8'h01);
        push(4'b0000);
        check("R6 event drops", {7'd0, done_evt_o}, 8'h00);
        check("R3 head first", status_o, 8'hC0);
        pop_one();
        check("R3 second", status_o, 8'h88);
        pop_one();
        check("R3 third", status_o, 8'h80);
        pop_one();
        check("R3 drained", status_o, 8'h00);
    endtask

    task automatic t_empty_pop();
        pop_one();
        pop_one();
        check("R4 empty pop reads zero", status_o, 8'h00);
        push(4'b1001);
        pop_one();
        check("R4 no stale after pop", status_o, 8'h00);
        push(4'b0001);
        check("R4 later push intact", status_o, 8'h88);
        pop_one();
    endtask

    task automatic t_overflow();
        push(4'b0000);
        push(4'b1000);
        push(4'b0001);
        push(4'b0000);
        push(4'b1000);   // dropped: full
        check("R6 event on dropped", {7'd0, done_evt_o}, 8'h01);
        push(4'b0001);   // dropped again
        check("R5 head unchanged", status_o, 8'h80);
        pop_one();
        check("R5 older 2", status_o, 8'hC0);
        pop_one();
        check("R5 older 3", status_o, 8'h88);
        pop_one();
        check("R5 newest marked", status_o, 8'h84);
        pop_one();
        check("R5 dropped not stored", status_o, 8'h00);
    endtask

    task automatic t_full_swap();
        push(4'b0000);
        push(4'b0000);
        push(4'b0000);
        push(4'b0000);
        step(1'b1, 4'b1000, 1'b1, 1'b0);   // push and pop together
        pop_one();
        pop_one();
        check("R9 no overflow mark", status_o, 8'h80);
        pop_one();
        check("R9 pushed entry kept", status_o, 8'hC0);
        pop_one();
        check("R9 drained", status_o, 8'h00);
    endtask

    task automatic t_lock();
        push(4'b0100);
        check("R7 jabber byte", status_o, 8'hA0);
        check("R7 hold set", {7'd0, tx_hold_o}, 8'h01);
        pop_one();
        push(4'b0000);
        check("R7 hold stays", {7'd0, tx_hold_o}, 8'h01);
        step(1'b0, 4'b0000, 1'b0, 1'b1);
        check("R8 reset empties", status_o, 8'h00);
        check("R8 reset clears hold", {7'd0, tx_hold_o}, 8'h00);
        push(4'b0010);
        check("R7 underrun hold", {7'd0, tx_hold_o}, 8'h01);
        check("R2 underrun byte", status_o, 8'h90);
        step(1'b1, 4'b1100, 1'b1, 1'b1);   // reset wins over done and pop
        check("R8 override store", status_o, 8'h00);
        check("R8 override hold", {7'd0, tx_hold_o}, 8'h00);
        check("R8 override event", {7'd0, done_evt_o}, 8'h00);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_encode();
        t_order();
        t_empty_pop();
        t_overflow();
        t_full_swap();
        t_lock();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule